// File: doc/BRIEF.md
# Sector Request Splitter

This block sits in front of a sectored cache. It takes one memory request (a base address, a size in bytes, a 128-bit byte-enable mask, a 4-bit sector mask and an opaque tag) and turns it into a series of child requests. Each child touches exactly one 32-byte sector of a 128-byte line. The request size and the sector mask select the splitting rule. The rules cover a full line, a half line, a pass-through for a request that already fits one sector, and a general per-sector expansion.

The request enters through a valid/ready input. The children leave one per handshake through a valid/ready output. Back-pressure works as follows. `in_ready` is high only while no children are pending, so a new request is taken no earlier than the cycle after the final child's handshake. A child held with `out_ready` low keeps all of its fields stable. A request that would yield no child is consumed without output, and the block reports it with a one-cycle `err_empty` pulse.

Top module: `sector_splitter`

## Requirements
- R1: A request of size 32 whose sector mask has exactly one bit set produces a single child whose address, byte mask and sector mask are identical to the request's.
- R2: A request of size 128 produces four children for sectors 0,1,2,3 in that order, whatever its sector mask. Child i has address base + 32*i and a sector mask with only bit i set.
- R3: A request of size 64 whose sector mask is 4'b1111 or 4'b0000 produces two children. They are sectors 0 and 1 when address bits [6:0] are zero, and sectors 2 and 3 otherwise.
- R4: In the R3 case, both children carry the request's base address unchanged.
- R5: Every other request produces one child per set bit of its sector mask, in ascending sector order. The child for sector i has address base + 32*i and sector mask bit i alone set.
- R6: Outside the R1 case, the byte mask of the child for sector i is the request byte mask ANDed with a mask of ones over bytes 32*i to 32*i+31.
- R7: A request that yields no child raises `err_empty` for exactly one cycle, the cycle after acceptance. It produces no child, and the block is ready again in that same cycle.
- R8: After reset, and whenever no child is pending, `in_ready` is high. From acceptance until the handshake of the last child, `in_ready` is low.
- R9: While `out_valid` is high and `out_ready` is low, all output fields remain unchanged in the next cycle.
- R10: Every child carries the request's tag. `out_last` is high only on the final child of a request, and `out_valid` falls in the cycle after that child's handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | ADDR_W (32) | Request base address in bytes |
| in_size | input | SIZE_W (8) | Request size in bytes |
| in_bmask | input | 128 | Request byte enables, bit k for line byte k |
| in_smask | input | 4 | Request sector mask, bit i for sector i |
| in_tag | input | TAG_W (12) | Opaque request tag |
| out_valid | output | 1 | Child valid |
| out_ready | input | 1 | Downstream accepts the child |
| out_addr | output | ADDR_W (32) | Child address |
| out_bmask | output | 128 | Child byte enables |
| out_smask | output | 4 | Child one-hot sector mask |
| out_tag | output | TAG_W (12) | Tag copied from the request |
| out_last | output | 1 | Final child of the current request |
| err_empty | output | 1 | One-cycle pulse when a request yields no child |

## Verification
The bench goes after the rule boundaries, where a wrong priority sends a request down the wrong path. A size-32 request with two mask bits must not be treated as a pass-through. A size-128 request with an empty mask must still yield four children. A size-64 request with a partial mask must use offset addresses rather than the half-line rule, and the half-line case must pick its sector pair from line alignment and keep the base address. A design that lost the byte-mask restriction would show bytes from neighbouring sectors in a child. A design that took the next request early, or that changed fields under a stall, would fail the ready and stability checks made while `out_ready` is driven randomly. A zero-child request is checked for its error pulse and for the absence of any child.

// File: rtl/ssplit_pkg.sv
package ssplit_pkg;
  parameter int SECTOR_BYTES = 32;
  parameter int NUM_SECTORS  = 4;
  parameter int LINE_BYTES   = SECTOR_BYTES * NUM_SECTORS;
  parameter int DEF_ADDR_W   = 32;
  parameter int DEF_SIZE_W   = 8;
  parameter int DEF_TAG_W    = 12;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_FULL = 2'd1,
    MODE_HALF = 2'd2,
    MODE_EACH = 2'd3
  } split_mode_e;
endpackage

// File: rtl/ssplit_classify.sv
module ssplit_classify
  import ssplit_pkg::*;
#(
  parameter int NSEC      = NUM_SECTORS,
  parameter int SEC_BYTES = SECTOR_BYTES,
  parameter int SIZE_W    = DEF_SIZE_W,
  localparam int LINE     = NSEC * SEC_BYTES,
  localparam int LINE_LOG = $clog2(LINE)
) (
  input  logic [SIZE_W-1:0]   size,
  input  logic [NSEC-1:0]     smask,
  input  logic [LINE_LOG-1:0] line_off,
  output split_mode_e         mode,
  output logic [NSEC-1:0]     sel
);
  localparam logic [SIZE_W-1:0] SZ_SEC  = SIZE_W'(SEC_BYTES);
  localparam logic [SIZE_W-1:0] SZ_LINE = SIZE_W'(LINE);
  localparam logic [SIZE_W-1:0] SZ_HALF = SIZE_W'(LINE / 2);
  localparam logic [NSEC-1:0]   LO_HALF = NSEC'((1 << (NSEC / 2)) - 1);

  always_comb begin
    if (size == SZ_SEC && $countones(smask) == 1) begin
      mode = MODE_PASS;
      sel  = smask;
    end else if (size == SZ_LINE) begin
      mode = MODE_FULL;
      sel  = '1;
    end else if (size == SZ_HALF && (smask == '1 || smask == '0)) begin
      mode = MODE_HALF;
      sel  = (line_off == '0) ? LO_HALF : ~LO_HALF;
    end else begin
      mode = MODE_EACH;
      sel  = smask;
    end
  end
endmodule

// File: rtl/ssplit_lanes.sv
module ssplit_lanes
  import ssplit_pkg::*;
#(
  parameter int NSEC      = NUM_SECTORS,
  parameter int SEC_BYTES = SECTOR_BYTES,
  localparam int BM_W     = NSEC * SEC_BYTES,
  localparam int IDX_W    = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [BM_W-1:0]  parent,
  output logic [BM_W-1:0]  clipped
);
  logic [BM_W-1:0] window [NSEC];

  for (genvar s = 0; s < NSEC; s++) begin : g_win
    assign window[s] = BM_W'({SEC_BYTES{1'b1}}) << (s * SEC_BYTES);
  end

  assign clipped = parent & window[idx];
endmodule

// File: rtl/ssplit_seq.sv
module ssplit_seq
  import ssplit_pkg::*;
#(
  parameter int NSEC   = NUM_SECTORS,
  localparam int IDX_W = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NSEC-1:0]  sel,
  input  logic             advance,
  output logic             busy,
  output logic [IDX_W-1:0] cur_idx,
  output logic             last
);
  logic [NSEC-1:0] rem_q;
  logic [NSEC-1:0] cur_bit;

  always_comb begin
    cur_idx = '0;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (rem_q[i]) cur_idx = IDX_W'(i);
    end
    cur_bit = NSEC'(1) << cur_idx;
  end

  assign busy = |rem_q;
  assign last = ((rem_q & ~cur_bit) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (load) begin
      rem_q <= sel;
    end else if (advance) begin
      rem_q <= rem_q & ~cur_bit;
    end
  end
endmodule

// File: rtl/sector_splitter.sv
module sector_splitter
  import ssplit_pkg::*;
#(
  parameter int ADDR_W    = DEF_ADDR_W,
  parameter int SIZE_W    = DEF_SIZE_W,
  parameter int TAG_W     = DEF_TAG_W,
  parameter int NSEC      = NUM_SECTORS,
  parameter int SEC_BYTES = SECTOR_BYTES,
  localparam int BM_W     = NSEC * SEC_BYTES,
  localparam int IDX_W    = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int SEC_LOG  = $clog2(SEC_BYTES),
  localparam int LINE_LOG = $clog2(BM_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [BM_W-1:0]   in_bmask,
  input  logic [NSEC-1:0]   in_smask,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [BM_W-1:0]   out_bmask,
  output logic [NSEC-1:0]   out_smask,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_last,
  output logic              err_empty
);
  split_mode_e       cls_mode;
  logic [NSEC-1:0]   cls_sel;
  split_mode_e       mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BM_W-1:0]   bmask_q;
  logic [NSEC-1:0]   smask_q;
  logic [TAG_W-1:0]  tag_q;
  logic              err_q;
  logic              busy;
  logic [IDX_W-1:0]  cur_idx;
  logic              seq_last;
  logic [BM_W-1:0]   lane_bmask;
  logic              accept;
  logic              fire;

  ssplit_classify #(.NSEC(NSEC), .SEC_BYTES(SEC_BYTES), .SIZE_W(SIZE_W)) u_cls (
    .size     (in_size),
    .smask    (in_smask),
    .line_off (in_addr[LINE_LOG-1:0]),
    .mode     (cls_mode),
    .sel      (cls_sel)
  );

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign fire     = out_valid && out_ready;

  ssplit_seq #(.NSEC(NSEC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept && (cls_sel != '0)),
    .sel     (cls_sel),
    .advance (fire),
    .busy    (busy),
    .cur_idx (cur_idx),
    .last    (seq_last)
  );

  ssplit_lanes #(.NSEC(NSEC), .SEC_BYTES(SEC_BYTES)) u_lanes (
    .idx     (cur_idx),
    .parent  (bmask_q),
    .clipped (lane_bmask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MODE_PASS;
      addr_q  <= '0;
      bmask_q <= '0;
      smask_q <= '0;
      tag_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && (cls_sel == '0);
      if (accept) begin
        mode_q  <= cls_mode;
        addr_q  <= in_addr;
        bmask_q <= in_bmask;
        smask_q <= in_smask;
        tag_q   <= in_tag;
      end
    end
  end

  logic [ADDR_W-1:0] sec_offset;
  assign sec_offset = ADDR_W'({cur_idx, {SEC_LOG{1'b0}}});

  always_comb begin
    out_valid = busy;
    out_last  = seq_last;
    out_tag   = tag_q;
    err_empty = err_q;
    unique case (mode_q)
      MODE_PASS: begin
        out_addr  = addr_q;
        out_bmask = bmask_q;
        out_smask = smask_q;
      end
      MODE_HALF: begin
        out_addr  = addr_q;
        out_bmask = lane_bmask;
        out_smask = NSEC'(1) << cur_idx;
      end
      default: begin
        out_addr  = addr_q + sec_offset;
        out_bmask = lane_bmask;
        out_smask = NSEC'(1) << cur_idx;
      end
    endcase
  end
endmodule

// File: rtl/ssplit_checker.sv
module ssplit_checker #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 12,
  parameter int NSEC   = 4,
  parameter int BM_W   = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [BM_W-1:0]   out_bmask,
  input logic [NSEC-1:0]   out_smask,
  input logic [TAG_W-1:0]  out_tag,
  input logic              out_last,
  input logic              err_empty
);
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) &&
      $stable(out_bmask) && $stable(out_smask) && $stable(out_tag) &&
      $stable(out_last)));

  p_block_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_err_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_empty |-> (!out_valid && in_ready));

  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_empty |=> !err_empty);

  p_child_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_smask) == 1));

  p_last_drains_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

bind sector_splitter ssplit_checker #(
  .ADDR_W (ADDR_W),
  .TAG_W  (TAG_W),
  .NSEC   (NSEC),
  .BM_W   (BM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_addr  (out_addr),
  .out_bmask (out_bmask),
  .out_smask (out_smask),
  .out_tag   (out_tag),
  .out_last  (out_last),
  .err_empty (err_empty)
);

// File: tb/sector_splitter_tb.sv
module sector_splitter_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  in_addr;
  logic [7:0]   in_size;
  logic [127:0] in_bmask;
  logic [3:0]   in_smask;
  logic [11:0]  in_tag;
  logic         out_valid;
  logic         out_ready;
  logic [31:0]  out_addr;
  logic [127:0] out_bmask;
  logic [3:0]   out_smask;
  logic [11:0]  out_tag;
  logic         out_last;
  logic         err_empty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int           e_cnt;
  logic [31:0]  e_addr [4];
  logic [127:0] e_bm   [4];
  logic [3:0]   e_sm   [4];

  always #5 clk = ~clk;

  sector_splitter dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_size(in_size), .in_bmask(in_bmask), .in_smask(in_smask), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_bmask(out_bmask), .out_smask(out_smask), .out_tag(out_tag),
    .out_last(out_last), .err_empty(err_empty)
  );

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model(logic [31:0] a, logic [7:0] sz, logic [3:0] sm, logic [127:0] bm);
    logic [3:0] pick;
    bit offs;
    e_cnt = 0;
    if (sz == 8'd32 && $countones(sm) == 1) begin
      e_cnt = 1; e_addr[0] = a; e_bm[0] = bm; e_sm[0] = sm;
      return;
    end
    if (sz == 8'd128) begin
      pick = 4'b1111; offs = 1'b1;
    end else if (sz == 8'd64 && (sm == 4'b1111 || sm == 4'b0000)) begin
      pick = (a[6:0] == 7'd0) ? 4'b0011 : 4'b1100; offs = 1'b0;
    end else begin
      pick = sm; offs = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      if (pick[i]) begin
        e_addr[e_cnt] = offs ? a + 32'(i * 32) : a;
        e_bm[e_cnt]   = bm & (128'hFFFF_FFFF << (i * 32));
        e_sm[e_cnt]   = 4'b0001 << i;
        e_cnt++;
      end
    end
  endtask

  // req names the requirement that this request's children exercise
  task automatic run_req(string req, logic [31:0] a, logic [7:0] sz, logic [3:0] sm,
                         logic [127:0] bm, logic [11:0] tg);
    int k;
    int guard;
    bit stalled;
    logic [31:0]  s_addr;
    logic [127:0] s_bm;
    logic [3:0]   s_sm;
    model(a, sz, sm, bm);
    @(negedge clk);
    chk("R8", "in_ready idle", 128'(in_ready), 128'd1);
    in_valid = 1'b1; in_addr = a; in_size = sz; in_smask = sm; in_bmask = bm; in_tag = tg;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (e_cnt == 0) begin
      chk("R7", "err_empty pulse", 128'(err_empty), 128'd1);
      chk("R7", "no child", 128'(out_valid), 128'd0);
      chk("R7", "ready after error", 128'(in_ready), 128'd1);
      @(negedge clk);
      chk("R7", "err_empty single cycle", 128'(err_empty), 128'd0);
      return;
    end
    k = 0; guard = 0; stalled = 1'b0;
    s_addr = '0; s_bm = '0; s_sm = '0;
    while (k < e_cnt && guard < 200) begin
      out_ready = ($urandom % 4) != 0;
      if (stalled) begin
        chk("R9", "addr held", 128'(out_addr), 128'(s_addr));
        chk("R9", "bmask held", out_bmask, s_bm);
        chk("R9", "smask held", 128'(out_smask), 128'(s_sm));
      end
      chk("R8", "valid while pending", 128'(out_valid), 128'd1);
      chk("R8", "in_ready low while pending", 128'(in_ready), 128'd0);
      if (out_valid && out_ready) begin
        chk(req, "child addr", 128'(out_addr), 128'(e_addr[k]));
        chk("R6", "child bmask", out_bmask, e_bm[k]);
        chk(req, "child smask", 128'(out_smask), 128'(e_sm[k]));
        chk("R10", "child tag", 128'(out_tag), 128'(tg));
        chk("R10", "child last", 128'(out_last), 128'(k == e_cnt - 1));
        k++;
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        s_addr = out_addr; s_bm = out_bmask; s_sm = out_smask;
      end
      guard++;
      @(negedge clk);
    end
    if (guard >= 200) chk(req, "children delivered", 128'(k), 128'(e_cnt));
    chk("R10", "valid drops after last", 128'(out_valid), 128'd0);
    chk("R8", "ready after last", 128'(in_ready), 128'd1);
    out_ready = 1'b0;
  endtask

  function automatic logic [127:0] rnd_bm();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_addr = '0; in_size = '0; in_bmask = '0; in_smask = '0; in_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "reset in_ready", 128'(in_ready), 128'd1);
    chk("R8", "reset out_valid", 128'(out_valid), 128'd0);
    chk("R7", "reset err_empty", 128'(err_empty), 128'd0);
    rst_n = 1'b1;

    run_req("R1", 32'h0000_1040, 8'd32,  4'b0100, rnd_bm(), 12'h111);
    run_req("R2", 32'h0000_2000, 8'd128, 4'b0000, rnd_bm(), 12'h222);
    run_req("R2", 32'h0000_3000, 8'd128, 4'b1010, {128{1'b1}}, 12'h223);
    run_req("R3", 32'h0000_4000, 8'd64,  4'b1111, rnd_bm(), 12'h333);
    run_req("R4", 32'h0000_4040, 8'd64,  4'b0000, rnd_bm(), 12'h334);
    run_req("R5", 32'h0000_5000, 8'd64,  4'b0101, rnd_bm(), 12'h444);
    run_req("R5", 32'h0000_6000, 8'd32,  4'b0011, rnd_bm(), 12'h445);
    run_req("R5", 32'h0000_7000, 8'd96,  4'b1011, rnd_bm(), 12'h446);
    run_req("R7", 32'h0000_8000, 8'd32,  4'b0000, rnd_bm(), 12'h555);
    run_req("R7", 32'h0000_8800, 8'd96,  4'b0000, rnd_bm(), 12'h556);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] sz;
      logic [31:0] a;
      case ($urandom % 5)
        0: sz = 8'd32;
        1: sz = 8'd64;
        2: sz = 8'd128;
        3: sz = 8'd96;
        default: sz = 8'd64;
      endcase
      a = $urandom & 32'hFFFF_FFE0;
      if ($urandom % 2 == 0) a[6:0] = 7'd0;
      run_req("R5", a, sz, 4'($urandom), rnd_bm(), 12'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule